// File: doc/BRIEF.md
# Triggered Pipeline and Derandomizer Readout

This block sits on the readout path of a calorimeter front-end board. Every clock cycle is one beam crossing. On each crossing it writes one sample row for a group of channels into a circular pipeline memory. Each sample carries an energy and two error flags. The rows wait there until the trigger's accept decision arrives a fixed number of crossings later.

An accept takes the current pipeline write position, subtracts a programmable latency, and copies a fixed window of consecutive rows, starting there, into a derandomizing store. That store holds several accepted events. A readout state machine then serializes each stored event into 16-bit words, one record per channel, and pushes the words into a small output FIFO. The FIFO presents them with a valid/ready handshake.

Accepts that cannot be stored are discarded and counted. They still consume an event number, so the gap is visible downstream.

Top module: `trg_pipe_readout`

The copy engine has two states. In `CP_IDLE` it waits for an accept; a taken accept moves it to `CP_RUN`. `CP_RUN` copies one row per cycle and returns to `CP_IDLE` after the last row of the window.

The readout engine has six states:
- `RD_IDLE` moves to `RD_ID` when a completed event is stored.
- `RD_ID` moves to `RD_BC`.
- `RD_BC` moves to `RD_DATA`.
- `RD_DATA` stays for WIN words, then moves to `RD_SUM`.
- `RD_SUM` moves to `RD_TAIL`.
- `RD_TAIL` returns to `RD_ID` for the next channel, or to `RD_IDLE` after the last channel, which frees the slot.

Every transition out of a word-emitting state needs a free FIFO entry.

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` is 0 and `drop_count` is 0.
- R2: Each cycle after reset, the row on `row_in` is stored as crossing number n (n counts cycles from reset release). An accept in crossing t with latency L yields WIN data words per channel: those of crossings t-L to t-L+WIN-1.
- R3: The second word of each channel record is {channel index in bits [15:12], (t-L) mod 4096 in bits [11:0]}, using a 12-bit crossing counter that wraps.
- R4: An event is emitted as NCH consecutive records in ascending channel order. Each record has WIN+4 words: event ID, crossing word, WIN data words, sum word, tail word. No word is missing or repeated.
- R5: Each channel occupies 16 bits of `row_in` (channel c at bits [16c+15:16c]). Within those 16 bits, bit 15 is the cap error, bit 14 the frame error, and bits [13:0] the energy. A data word is that 16-bit field unchanged.
- R6: The sum word is the sum of the WIN 14-bit energies of that channel, zero-extended and taken modulo 2^16.
- R7: The tail word holds: bit 15, the OR of the window's cap errors; bit 14, the OR of its frame errors; bits [13:AW], zero; bits [AW-1:0], the pipeline start address (t-L) mod 2^AW.
- R8: An accept is dropped when NEVT events already occupy the store, or when it arrives while the copy of an earlier accept is still running. Each drop raises `drop_count` by one in the next cycle; nothing else changes it.
- R9: The event ID is a 16-bit count of all accepts since reset, dropped ones included, starting at 0.
- R10: While `out_valid` is high and `out_ready` low, `out_data` and `out_valid` hold. Back-pressure only delays words; it never loses one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| row_in | input | NCH*16 | Sample row for this crossing, one 16-bit field per channel |
| trig_accept | input | 1 | Trigger accept for the current crossing |
| latency | input | AW | Pipeline latency in crossings, sampled at each accept |
| out_data | output | 16 | Output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| drop_count | output | OVFW | Number of discarded accepts |

## Verification
The properties rely on the environment holding reset from time zero, and on `out_ready` being driven between clock edges. The drop-counter properties also treat any accept as a possible drop source.

The stimulus keeps `latency` at or below 2^AW − WIN, so the window is read before the pipeline overwrites it. It also issues accepts only once at least `latency` crossings have passed since reset, so every window row was written after reset.

Drops are provoked on purpose, by a second accept three cycles into a copy and by filling the store while `out_ready` is held low. Otherwise accepts are spaced well apart, so the bench knows which accepts must be kept.

// File: rtl/trg_rdo_pkg.sv
package trg_rdo_pkg;

    localparam int SW  = 16;   // stored sample and output word width
    localparam int EW  = 14;   // energy field width inside a sample
    localparam int BCW = 12;   // crossing counter width
    localparam int CHF = 4;    // channel field width in the crossing word

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_ID,
        RD_BC,
        RD_DATA,
        RD_SUM,
        RD_TAIL
    } rd_state_e;

    typedef enum logic {
        CP_IDLE,
        CP_RUN
    } cp_state_e;

endpackage

// File: rtl/trg_pipe_ram.sv
module trg_pipe_ram #(
    parameter int NCH = 2,
    parameter int AW  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NCH*trg_rdo_pkg::SW-1:0] wr_row,
    input  logic [AW-1:0]                 rd_addr,
    output logic [AW-1:0]                 wr_ptr,
    output logic [NCH*trg_rdo_pkg::SW-1:0] rd_row
);
    localparam int DEPTH = 1 << AW;
    localparam int ROWW  = NCH * trg_rdo_pkg::SW;

    logic [ROWW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            mem[wr_ptr] <= wr_row;
        end
    end

    assign rd_row = mem[rd_addr];

endmodule

// File: rtl/trg_derand_store.sv
module trg_derand_store #(
    parameter int ROWW = 32,
    parameter int NROW = 40
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [$clog2(NROW)-1:0] waddr,
    input  logic [ROWW-1:0]         wrow,
    input  logic [$clog2(NROW)-1:0] raddr,
    output logic [ROWW-1:0]         rrow
);
    logic [ROWW-1:0] mem [NROW];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wrow;
        end
    end

    assign rrow = mem[raddr];

endmodule

// File: rtl/trg_out_fifo.sv
module trg_out_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wp;
    logic [PW-1:0]   rp;
    logic [CNTW-1:0] cnt;
    logic            do_push;
    logic            do_pop;

    assign full    = (cnt == CNTW'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

endmodule

// File: rtl/trg_pipe_readout.sv
module trg_pipe_readout
    import trg_rdo_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int AW     = 6,
    parameter int WIN    = 10,
    parameter int NEVT   = 4,
    parameter int FDEPTH = 4,
    parameter int OVFW   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH*16-1:0]   row_in,
    input  logic                trig_accept,
    input  logic [AW-1:0]       latency,
    output logic [15:0]         out_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OVFW-1:0]     drop_count
);
    localparam int ROWW  = NCH * SW;
    localparam int IW    = $clog2(WIN);
    localparam int SLW   = (NEVT > 1) ? $clog2(NEVT) : 1;
    localparam int CW    = $clog2(NEVT + 1);
    localparam int DROWS = NEVT * WIN;
    localparam int DAW   = $clog2(DROWS);
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PADW  = SW - 2 - AW;

    // crossing bookkeeping
    logic [BCW-1:0]  bc_cnt;
    logic [15:0]     evt_id;
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   start_addr;
    logic [BCW-1:0]  start_bc;

    // copy engine
    cp_state_e       cp_state, cp_next;
    logic [IW-1:0]   cp_idx;
    logic [AW-1:0]   cp_addr;
    logic [ROWW-1:0] pipe_row;
    logic [SLW-1:0]  wslot;
    logic            cp_last;
    logic            acc_take;
    logic            acc_drop;
    logic [DAW-1:0]  cp_waddr;

    // occupancy
    logic [CW-1:0]   occ;
    logic [CW-1:0]   ready_cnt;
    logic            rel;

    // per-slot header and channel summaries
    logic [15:0]     hdr_id   [NEVT];
    logic [BCW-1:0]  hdr_bc   [NEVT];
    logic [AW-1:0]   hdr_addr [NEVT];
    logic [SW-1:0]   acc_sum  [NEVT][NCH];
    logic            acc_cap  [NEVT][NCH];
    logic            acc_frm  [NEVT][NCH];

    // readout engine
    rd_state_e       rd_state, rd_next;
    logic [CHW-1:0]  rd_ch;
    logic [IW-1:0]   rd_idx;
    logic [SLW-1:0]  rslot;
    logic [DAW-1:0]  rd_raddr;
    logic [ROWW-1:0] drow;
    logic [15:0]     word;
    logic            push;
    logic            fifo_full;
    logic            last_ch;
    logic            last_idx;

    // ---------------- pipeline memory ----------------
    trg_pipe_ram #(.NCH(NCH), .AW(AW)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .wr_row (row_in),
        .rd_addr(cp_addr),
        .wr_ptr (wr_ptr),
        .rd_row (pipe_row)
    );

    // ---------------- accept decoder ----------------
    assign start_addr = wr_ptr - latency;
    assign start_bc   = bc_cnt - {{(BCW - AW){1'b0}}, latency};
    assign acc_take   = trig_accept && (cp_state == CP_IDLE) && (occ != CW'(NEVT));
    assign acc_drop   = trig_accept && !acc_take;
    assign cp_last    = (cp_state == CP_RUN) && (cp_idx == IW'(WIN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bc_cnt     <= '0;
            evt_id     <= '0;
            drop_count <= '0;
            occ        <= '0;
            ready_cnt  <= '0;
        end else begin
            bc_cnt    <= bc_cnt + 1'b1;
            occ       <= occ + CW'(acc_take) - CW'(rel);
            ready_cnt <= ready_cnt + CW'(cp_last) - CW'(rel);
            if (trig_accept) begin
                evt_id <= evt_id + 1'b1;
            end
            if (acc_drop) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

    // ---------------- copy engine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cp_state <= CP_IDLE;
        end else begin
            cp_state <= cp_next;
        end
    end

    always_comb begin
        cp_next = cp_state;
        unique case (cp_state)
            CP_IDLE: if (acc_take) cp_next = CP_RUN;
            CP_RUN:  if (cp_last)  cp_next = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_idx  <= '0;
            cp_addr <= '0;
            wslot   <= '0;
        end else if (acc_take) begin
            cp_idx          <= '0;
            cp_addr         <= start_addr;
            hdr_id[wslot]   <= evt_id;
            hdr_bc[wslot]   <= start_bc;
            hdr_addr[wslot] <= start_addr;
            for (int c = 0; c < NCH; c++) begin
                acc_sum[wslot][c] <= '0;
                acc_cap[wslot][c] <= 1'b0;
                acc_frm[wslot][c] <= 1'b0;
            end
        end else if (cp_state == CP_RUN) begin
            cp_idx  <= cp_idx + 1'b1;
            cp_addr <= cp_addr + 1'b1;
            for (int c = 0; c < NCH; c++) begin
                acc_sum[wslot][c] <= acc_sum[wslot][c] + SW'(pipe_row[c*SW +: EW]);
                acc_cap[wslot][c] <= acc_cap[wslot][c] | pipe_row[c*SW + SW - 1];
                acc_frm[wslot][c] <= acc_frm[wslot][c] | pipe_row[c*SW + SW - 2];
            end
            if (cp_last) begin
                wslot <= (wslot == SLW'(NEVT - 1)) ? '0 : wslot + 1'b1;
            end
        end
    end

    assign cp_waddr = DAW'(wslot) * DAW'(WIN) + DAW'(cp_idx);
    assign rd_raddr = DAW'(rslot) * DAW'(WIN) + DAW'(rd_idx);

    trg_derand_store #(.ROWW(ROWW), .NROW(DROWS)) u_store (
        .clk  (clk),
        .we   (cp_state == CP_RUN),
        .waddr(cp_waddr),
        .wrow (pipe_row),
        .raddr(rd_raddr),
        .rrow (drow)
    );

    // ---------------- readout engine ----------------
    assign last_ch  = (rd_ch == CHW'(NCH - 1));
    assign last_idx = (rd_idx == IW'(WIN - 1));
    assign rel      = (rd_state == RD_TAIL) && push && last_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= RD_IDLE;
        end else begin
            rd_state <= rd_next;
        end
    end

    always_comb begin
        rd_next = rd_state;
        unique case (rd_state)
            RD_IDLE: if (ready_cnt != '0) rd_next = RD_ID;
            RD_ID:   if (push) rd_next = RD_BC;
            RD_BC:   if (push) rd_next = RD_DATA;
            RD_DATA: if (push && last_idx) rd_next = RD_SUM;
            RD_SUM:  if (push) rd_next = RD_TAIL;
            RD_TAIL: if (push) rd_next = last_ch ? RD_IDLE : RD_ID;
        endcase
    end

    always_comb begin
        word = '0;
        unique case (rd_state)
            RD_IDLE: word = '0;
            RD_ID:   word = hdr_id[rslot];
            RD_BC:   word = {{(CHF - CHW){1'b0}}, rd_ch, hdr_bc[rslot]};
            RD_DATA: word = drow[rd_ch*SW +: SW];
            RD_SUM:  word = acc_sum[rslot][rd_ch];
            RD_TAIL: word = {acc_cap[rslot][rd_ch], acc_frm[rslot][rd_ch],
                             {PADW{1'b0}}, hdr_addr[rslot]};
        endcase
        push = (rd_state != RD_IDLE) && !fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ch  <= '0;
            rd_idx <= '0;
            rslot  <= '0;
        end else if (push) begin
            if (rd_state == RD_DATA) begin
                rd_idx <= last_idx ? '0 : rd_idx + 1'b1;
            end
            if (rd_state == RD_TAIL) begin
                rd_ch <= last_ch ? '0 : rd_ch + 1'b1;
                if (last_ch) begin
                    rslot <= (rslot == SLW'(NEVT - 1)) ? '0 : rslot + 1'b1;
                end
            end
        end
    end

    trg_out_fifo #(.W(SW), .DEPTH(FDEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .din  (word),
        .full (fifo_full),
        .pop  (out_ready),
        .dout (out_data),
        .valid(out_valid)
    );

endmodule

// File: rtl/trg_pipe_readout_chk.sv
module trg_pipe_readout_chk #(
    parameter int OVFW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            trig_accept,
    input logic            out_valid,
    input logic            out_ready,
    input logic [15:0]     out_data,
    input logic [OVFW-1:0] drop_count
);

    // R1: quiet outputs right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && drop_count == '0));

    // R10: a stalled word holds
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: the drop counter only moves after an accept
    a_r8_drop_needs_accept: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> $past(trig_accept));

    // R8: the drop counter moves by at most one per cycle
    a_r8_drop_single_step: assert property (@(posedge clk) disable iff (rst)
        (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

endmodule

bind trg_pipe_readout trg_pipe_readout_chk #(.OVFW(OVFW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig_accept(trig_accept),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .drop_count (drop_count)
);

// File: tb/sim_trg_pipe_readout.sv
module sim_trg_pipe_readout;

    localparam int NCH  = 2;
    localparam int AW   = 6;
    localparam int WIN  = 10;
    localparam int NEVT = 4;
    localparam int ROWW = NCH * 16;
    localparam int PADW = 16 - 2 - AW;

    logic            clk = 1'b0;
    logic            rst;
    logic [ROWW-1:0] row_in;
    logic            trig_accept;
    logic [AW-1:0]   latency;
    logic [15:0]     out_data;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [15:0]     drop_count;

    trg_pipe_readout #(.NCH(NCH), .AW(AW), .WIN(WIN), .NEVT(NEVT)) u0 (
        .clk        (clk),
        .rst        (rst),
        .row_in     (row_in),
        .trig_accept(trig_accept),
        .latency    (latency),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .drop_count (drop_count)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [15:0] expw [$];
    string       expt [$];

    typedef struct packed { int t; int lat; int id; } acc_t;
    acc_t pend [$];

    logic [ROWW-1:0] hist [4096];
    int  cyc     = 0;
    int  evid    = 0;
    int  exp_ovf = 0;
    bit  exp_drop  = 1'b0;
    bit  hold      = 1'b0;
    bit  force_max = 1'b0;
    int  rdy_pct   = 100;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Build the words an accepted event must produce (R2 R3 R4 R5 R6 R7 R9)
    task automatic build(acc_t a);
        int s;
        logic [15:0] sm;
        logic cf, ff;
        s = a.t - a.lat;
        for (int ch = 0; ch < NCH; ch++) begin
            expw.push_back(a.id[15:0]);                 expt.push_back("R9");
            expw.push_back({4'(ch), 12'(s)});           expt.push_back("R3");
            sm = '0; cf = 1'b0; ff = 1'b0;
            for (int k = 0; k < WIN; k++) begin
                logic [15:0] f;
                f = hist[(s + k) % 4096][ch*16 +: 16];
                expw.push_back(f);                      expt.push_back("R2,R5");
                sm = sm + {2'b00, f[13:0]};
                cf = cf | f[15];
                ff = ff | f[14];
            end
            expw.push_back(sm);                         expt.push_back("R6");
            expw.push_back({cf, ff, {PADW{1'b0}}, 6'(s)}); expt.push_back("R7");
        end
    endtask

    // sample row driver
    always @(negedge clk) begin
        logic [ROWW-1:0] r;
        for (int ch = 0; ch < NCH; ch++) begin
            if (force_max)
                r[ch*16 +: 16] = 16'h3FFF;
            else
                r[ch*16 +: 16] = {(($urandom % 8) == 0), (($urandom % 8) == 0), 14'($urandom)};
        end
        row_in = r;
    end

    // reference model of crossings and accepts
    always @(posedge clk) begin
        if (!rst) begin
            hist[cyc % 4096] = row_in;
            if (trig_accept) begin
                if (!exp_drop) pend.push_back('{cyc, int'(latency), evid});
                evid++;
            end
            while (pend.size() != 0 && cyc >= pend[0].t - pend[0].lat + WIN - 1) begin
                build(pend[0]);
                void'(pend.pop_front());
            end
            cyc++;
        end
    end

    // consumer: ready driver and word comparison
    always @(negedge clk) begin
        out_ready = hold ? 1'b0 : (($urandom % 100) < rdy_pct);
        #1;
        if (!rst && out_valid && out_ready) begin
            if (expw.size() == 0) begin
                check("R4 unexpected word", {16'h0, out_data}, 32'hFFFF_FFFF);
            end else begin
                check(expt[0], {16'h0, out_data}, {16'h0, expw[0]});
                void'(expw.pop_front());
                void'(expt.pop_front());
            end
        end
    end

    task automatic accept(bit drop);
        trig_accept = 1'b1;
        exp_drop    = drop;
        if (drop) exp_ovf++;
        @(negedge clk);
        trig_accept = 1'b0;
        exp_drop    = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((expw.size() != 0 || pend.size() != 0) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd7331));
        rst = 1'b1; trig_accept = 1'b0; latency = 6'd12;
        repeat (4) @(negedge clk);
        check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'h0, out_valid}, 32'h0);
        check("R1 drop count after reset", {16'h0, drop_count}, 32'h0);
        repeat (100) @(negedge clk);

        // directed latencies: typical, zero, largest allowed
        latency = 6'd20; accept(1'b0); drain();
        latency = 6'd0;  accept(1'b0); drain();
        latency = 6'(64 - WIN); accept(1'b0); drain();

        // R6: sum wraps modulo 2^16 with full-scale energies
        force_max = 1'b1;
        repeat (70) @(negedge clk);
        latency = 6'd30; accept(1'b0);
        repeat (WIN + 2) @(negedge clk);
        force_max = 1'b0;
        drain();

        // R8: accept during a running copy is dropped
        latency = 6'd15; accept(1'b0);
        repeat (2) @(negedge clk);
        accept(1'b1);
        drain();
        check("R8 drop during copy", {16'h0, drop_count}, 32'(exp_ovf));

        // R8/R10: fill the store under back-pressure
        hold = 1'b1;
        latency = 6'd25;
        for (int i = 0; i < NEVT + 2; i++) begin
            accept(i >= NEVT);
            repeat (WIN + 2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R8 drops when store full", {16'h0, drop_count}, 32'(exp_ovf));
        check("R10 head held valid", {31'h0, out_valid}, 32'h1);
        if (expw.size() != 0)
            check("R10 head word held", {16'h0, out_data}, {16'h0, expw[0]});
        hold = 1'b0;
        drain();

        // random phase, long enough to wrap the crossing counter (R3)
        rdy_pct = 70;
        for (int i = 0; i < 40; i++) begin
            latency = 6'($urandom % (64 - WIN + 1));
            repeat (1 + ($urandom % 20)) @(negedge clk);
            accept(1'b0);
            repeat (140) @(negedge clk);
        end
        rdy_pct = 100;
        drain();

        check("R4 all words delivered", 32'(expw.size()), 32'h0);
        check("R4 no trailing word", {31'h0, out_valid}, 32'h0);
        check("R8 final drop count", {16'h0, drop_count}, 32'(exp_ovf));
        report();
    end

endmodule